// File: doc/BRIEF.md
# Flash Command and Protection Sequencer

This block accepts keyed command words for a page-organised flash array, runs each accepted operation for a programmed number of clock cycles, and then applies its effect. The effect is one of the following: a page write from a one-word write buffer, with or without a preceding erase; a page erase; a whole-array erase; or an update of the protection state. While an operation runs, the block reports busy. When it finishes, a done flag is set. Rejected and aborted commands set error flags instead. A pending flag raises the interrupt line until software reads the status.

Protection state has four parts. There is one lock bit per region of consecutive pages. There are two general-purpose non-volatile bits: bit 0 enables the brownout detector and bit 1 enables the brownout reset. There is a security bit that closes the debug and parallel programming ports. There is also a fixed calibration field that nothing can alter. Only a command can set the security bit. To clear it, the dedicated erase pin must first be held long enough, and a full erase must then complete. Holding the pin also wipes the locks and the general-purpose bits. The array itself is modelled as one data word per page.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command word carries 0xA5 in bits 31:24, an operation code in bits 3:0 and a page number in bits 17:8; all other bits are zero. A word with the wrong key, a reserved bit set or a code outside 1..9 sets the programming-error flag and has no other effect. The codes are 1 program, 2 program without erase, 3 page erase, 4 full erase, 5 set lock, 6 clear lock, 7 set security, 8 set general bit, 9 clear general bit.
- R2: An accepted command holds busy high for exactly the operation's cycle count after the accepting edge. Its effect and the done flag appear on the edge where busy falls.
- R3: A program command replaces the page word with the write buffer. Program without erase leaves the bitwise AND of the old word and the buffer.
- R4: A page erase sets the addressed page to all ones. A full erase sets every page to all ones.
- R5: A program or page erase whose page lies in a locked region (region = page / 64) does not run. It sets the lock-error flag and changes nothing. A full erase is refused in the same way while any lock bit is set.
- R6: Set lock and clear lock set or clear the lock bit of the region that holds the page argument.
- R7: A command written while busy sets the programming-error flag and is dropped. The running operation completes unchanged.
- R8: A status read clears done, lock-error and programming-error. The interrupt output is high while any of the three is set.
- R9: Set and clear general bit act on the general-purpose bit selected by bit 8 of the command word.
- R10: Set security turns the security bit on and the external access grant off. No command clears the bit, and a full erase alone leaves it set.
- R11: Holding the erase pin high for more than ERASE_HOLD cycles (after a two-stage input synchroniser) clears every lock bit and both general-purpose bits, and arms security clearing. Shorter pulses have no effect.
- R12: The first full erase that completes after the pin has been honoured clears the security bit.
- R13: The calibration output always equals CAL_VALUE from reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word (key, page, code) |
| wbuf_we | input | 1 | Write-buffer load strobe |
| wbuf_wdata | input | DATA_W | Write-buffer data |
| stat_rd | input | 1 | Status read strobe, clears flags |
| rd_page | input | log2(PAGES) | Page selected for array read |
| rd_data | output | DATA_W | Word stored in the selected page |
| erase_pin | input | 1 | Asynchronous erase request pin |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completed flag |
| lock_err | output | 1 | Locked-region abort flag |
| prog_err | output | 1 | Bad key, bad code or busy rejection flag |
| irq | output | 1 | Interrupt, any flag pending |
| lock_bits | output | PAGES/PAGES_PER_REGION | Region lock bits |
| gp_bits | output | 2 | General-purpose bits (0 brownout enable, 1 brownout reset) |
| sec_on | output | 1 | Security bit |
| ext_access_ok | output | 1 | Debug and parallel port access granted |
| cal_bits | output | CAL_W | Calibration field |

## Verification
The bench keeps the default 1024-page, 64-page-region geometry, so the region edges at pages 63/64 and 127/128 are addressed as they would be in use. It shrinks the timings to 8 cycles for program, 4 for program without erase, 6 for page erase, 10 for full erase, 3 for bit writes and 20 for the erase pin hold. With these values the exact busy window, a rejection in the middle of an operation, and both a too-short and a long-enough pin pulse all fit in a few hundred cycles.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam logic [7:0] CMD_KEY = 8'hA5;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_PROG    = 4'd1,
    OP_PROG_NE = 4'd2,
    OP_PERASE  = 4'd3,
    OP_FERASE  = 4'd4,
    OP_SLOCK   = 4'd5,
    OP_CLOCK   = 4'd6,
    OP_SSEC    = 4'd7,
    OP_SGP     = 4'd8,
    OP_CGP     = 4'd9
  } fcs_op_e;

  function automatic logic op_known(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd9);
  endfunction

  // operations that address a single page and obey its region lock
  function automatic logic op_hits_page(input logic [3:0] c);
    return (c == OP_PROG) || (c == OP_PROG_NE) || (c == OP_PERASE);
  endfunction

endpackage

// File: rtl/fcs_pin_filter.sv
module fcs_pin_filter #(
  parameter int unsigned HOLD = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic fire
);
  localparam int unsigned CW = $clog2(HOLD + 2);
  localparam logic [CW-1:0] LIM = CW'(HOLD);
  localparam logic [CW-1:0] TOP = CW'(HOLD + 1);

  logic [1:0]    sync_q, sync_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl;

  assign lvl = sync_q[1];

  always_comb begin
    sync_d = {sync_q[0], pin_async};
    cnt_d  = cnt_q;
    if (!lvl)             cnt_d = '0;
    else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
  end

  // one pulse per assertion, when the level has outlasted the hold window
  assign fire = lvl && (cnt_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/fcs_array.sv
module fcs_array
  import fcs_pkg::*;
#(
  parameter int unsigned PAGES  = 1024,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAGE_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wbuf_we,
  input  logic [DATA_W-1:0] wbuf_wdata,
  input  logic              exec_valid,
  input  fcs_op_e           exec_op,
  input  logic [PAGE_W-1:0] exec_page,
  input  logic [PAGE_W-1:0] rd_page,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic [DATA_W-1:0] page_words [PAGES];

  always_comb wbuf_d = wbuf_we ? wbuf_wdata : wbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbuf_q <= '0;
    else        wbuf_q <= wbuf_d;
  end

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    logic              hit;
    logic [DATA_W-1:0] word_q, word_d;

    always_comb begin
      hit = exec_valid &&
            ((exec_op == OP_FERASE) ||
             (op_hits_page(exec_op) && (exec_page == PAGE_W'(g))));
      case (exec_op)
        OP_PROG:    word_d = wbuf_q;
        OP_PROG_NE: word_d = word_q & wbuf_q;
        default:    word_d = '1;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '1;
      else if (hit) word_q <= word_d;
    end

    assign page_words[g] = word_q;
  end

  assign rd_data = page_words[rd_page];
endmodule

// File: rtl/fcs_nvm.sv
module fcs_nvm
  import fcs_pkg::*;
#(
  parameter int unsigned REGIONS   = 16,
  parameter int unsigned REG_W     = $clog2(REGIONS),
  parameter int unsigned CAL_W     = 8,
  parameter logic [CAL_W-1:0] CAL_VALUE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_valid,
  input  fcs_op_e            exec_op,
  input  logic [REG_W-1:0]   exec_region,
  input  logic               exec_sel,
  input  logic               pin_fire,
  output logic [REGIONS-1:0] lock_bits,
  output logic [1:0]         gp_bits,
  output logic               sec_on,
  output logic               sec_armed,
  output logic [CAL_W-1:0]   cal_bits
);
  logic [REGIONS-1:0] lock_q, lock_d;
  logic [1:0]         gp_q, gp_d;
  logic               sec_q, sec_d, arm_q, arm_d;
  logic [CAL_W-1:0]   cal_q;
  logic               ferase_done;

  assign ferase_done = exec_valid && (exec_op == OP_FERASE);

  for (genvar r = 0; r < REGIONS; r++) begin : g_lock
    logic hit_set, hit_clr;
    always_comb begin
      hit_set = exec_valid && (exec_op == OP_SLOCK) && (exec_region == REG_W'(r));
      hit_clr = exec_valid && (exec_op == OP_CLOCK) && (exec_region == REG_W'(r));
      if (pin_fire)     lock_d[r] = 1'b0;
      else if (hit_set) lock_d[r] = 1'b1;
      else if (hit_clr) lock_d[r] = 1'b0;
      else              lock_d[r] = lock_q[r];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_gp
    logic sel;
    always_comb begin
      sel = exec_valid && (exec_sel == 1'(b));
      if (pin_fire)                         gp_d[b] = 1'b0;
      else if (sel && (exec_op == OP_SGP))  gp_d[b] = 1'b1;
      else if (sel && (exec_op == OP_CGP))  gp_d[b] = 1'b0;
      else                                  gp_d[b] = gp_q[b];
    end
  end

  always_comb begin
    sec_d = sec_q;
    if (exec_valid && (exec_op == OP_SSEC)) sec_d = 1'b1;
    if (ferase_done && arm_q)               sec_d = 1'b0;
    arm_d = arm_q;
    if (ferase_done) arm_d = 1'b0;
    if (pin_fire)    arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      gp_q   <= '0;
      sec_q  <= 1'b0;
      arm_q  <= 1'b0;
      cal_q  <= CAL_VALUE;
    end else begin
      lock_q <= lock_d;
      gp_q   <= gp_d;
      sec_q  <= sec_d;
      arm_q  <= arm_d;
      cal_q  <= cal_q;
    end
  end

  assign lock_bits = lock_q;
  assign gp_bits   = gp_q;
  assign sec_on    = sec_q;
  assign sec_armed = arm_q;
  assign cal_bits  = cal_q;
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int unsigned PAGE_W     = 10,
  parameter int unsigned REGIONS    = 16,
  parameter int unsigned REG_W      = $clog2(REGIONS),
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned PROG_CYC   = 8,
  parameter int unsigned PROGNE_CYC = 4,
  parameter int unsigned PERASE_CYC = 6,
  parameter int unsigned FERASE_CYC = 10,
  parameter int unsigned NVM_CYC    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [31:0]        cmd_wdata,
  input  logic               stat_rd,
  input  logic [REGIONS-1:0] lock_bits,
  output logic               busy,
  output logic               done,
  output logic               lock_err,
  output logic               prog_err,
  output logic               exec_valid,
  output fcs_op_e            exec_op,
  output logic [PAGE_W-1:0]  exec_page
);
  localparam logic [31:0] USED_MASK = 32'hFF00_000F | (((32'd1 << PAGE_W) - 32'd1) << 8);
  localparam logic [CNT_W-1:0] D_PROG   = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] D_PROGNE = CNT_W'(PROGNE_CYC - 1);
  localparam logic [CNT_W-1:0] D_PERASE = CNT_W'(PERASE_CYC - 1);
  localparam logic [CNT_W-1:0] D_FERASE = CNT_W'(FERASE_CYC - 1);
  localparam logic [CNT_W-1:0] D_NVM    = CNT_W'(NVM_CYC - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  fcs_op_e           op_q, op_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              done_q, done_d, lerr_q, lerr_d, perr_q, perr_d;

  logic [3:0]        code;
  logic [PAGE_W-1:0] arg_page;
  logic [REG_W-1:0]  arg_reg;
  logic              well_formed, target_locked, set_lerr, set_perr, start;
  logic [CNT_W-1:0]  dur;

  assign code     = cmd_wdata[3:0];
  assign arg_page = cmd_wdata[8 +: PAGE_W];
  assign arg_reg  = arg_page[PAGE_W-1 -: REG_W];
  assign exec_valid = busy_q && (cnt_q == '0);

  always_comb begin
    well_formed = (cmd_wdata[31:24] == CMD_KEY) &&
                  ((cmd_wdata & ~USED_MASK) == 32'd0) && op_known(code);
    if (op_hits_page(code))     target_locked = lock_bits[arg_reg];
    else if (code == OP_FERASE) target_locked = |lock_bits;
    else                        target_locked = 1'b0;
    case (code)
      OP_PROG:    dur = D_PROG;
      OP_PROG_NE: dur = D_PROGNE;
      OP_PERASE:  dur = D_PERASE;
      OP_FERASE:  dur = D_FERASE;
      default:    dur = D_NVM;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    page_d = page_q;
    set_perr = 1'b0;
    set_lerr = 1'b0;
    start    = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
    if (cmd_we) begin
      if (busy_q || !well_formed) set_perr = 1'b1;
      else if (target_locked)     set_lerr = 1'b1;
      else                        start    = 1'b1;
    end
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = dur;
      op_d   = fcs_op_e'(code);
      page_d = arg_page;
    end
    done_d = exec_valid | (done_q & ~stat_rd);
    lerr_d = set_lerr   | (lerr_q & ~stat_rd);
    perr_d = set_perr   | (perr_q & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
      page_q <= '0;
      done_q <= 1'b0;
      lerr_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      page_q <= page_d;
      done_q <= done_d;
      lerr_q <= lerr_d;
      perr_q <= perr_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign lock_err  = lerr_q;
  assign prog_err  = perr_q;
  assign exec_op   = op_q;
  assign exec_page = page_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int unsigned PAGES            = 1024,
  parameter int unsigned PAGES_PER_REGION = 64,
  parameter int unsigned DATA_W           = 32,
  parameter int unsigned CLK_KHZ          = 48000,
  parameter int unsigned PROG_CYC         = 4 * CLK_KHZ,
  parameter int unsigned PROGNE_CYC       = 2 * CLK_KHZ,
  parameter int unsigned PERASE_CYC       = 2 * CLK_KHZ,
  parameter int unsigned FERASE_CYC       = 10 * CLK_KHZ,
  parameter int unsigned NVM_CYC          = CLK_KHZ,
  parameter int unsigned ERASE_HOLD       = 50 * CLK_KHZ,
  parameter int unsigned CAL_W            = 8,
  parameter logic [CAL_W-1:0] CAL_VALUE   = 8'h5C
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cmd_we,
  input  logic [31:0]                            cmd_wdata,
  input  logic                                   wbuf_we,
  input  logic [DATA_W-1:0]                      wbuf_wdata,
  input  logic                                   stat_rd,
  input  logic [$clog2(PAGES)-1:0]               rd_page,
  output logic [DATA_W-1:0]                      rd_data,
  input  logic                                   erase_pin,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   lock_err,
  output logic                                   prog_err,
  output logic                                   irq,
  output logic [PAGES/PAGES_PER_REGION-1:0]      lock_bits,
  output logic [1:0]                             gp_bits,
  output logic                                   sec_on,
  output logic                                   ext_access_ok,
  output logic [CAL_W-1:0]                       cal_bits
);
  localparam int unsigned REGIONS = PAGES / PAGES_PER_REGION;
  localparam int unsigned PAGE_W  = $clog2(PAGES);
  localparam int unsigned REG_W   = $clog2(REGIONS);
  localparam int unsigned MAX_A   = (PROG_CYC > PROGNE_CYC) ? PROG_CYC : PROGNE_CYC;
  localparam int unsigned MAX_B   = (PERASE_CYC > FERASE_CYC) ? PERASE_CYC : FERASE_CYC;
  localparam int unsigned MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC = (MAX_C > NVM_CYC) ? MAX_C : NVM_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic              exec_valid;
  fcs_op_e           exec_op;
  logic [PAGE_W-1:0] exec_page;
  logic              pin_fire;
  logic              sec_armed;

  fcs_ctrl #(
    .PAGE_W(PAGE_W), .REGIONS(REGIONS), .REG_W(REG_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .PROGNE_CYC(PROGNE_CYC), .PERASE_CYC(PERASE_CYC),
    .FERASE_CYC(FERASE_CYC), .NVM_CYC(NVM_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .stat_rd(stat_rd), .lock_bits(lock_bits), .busy(busy), .done(done),
    .lock_err(lock_err), .prog_err(prog_err), .exec_valid(exec_valid),
    .exec_op(exec_op), .exec_page(exec_page)
  );

  fcs_array #(
    .PAGES(PAGES), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .wbuf_we(wbuf_we), .wbuf_wdata(wbuf_wdata),
    .exec_valid(exec_valid), .exec_op(exec_op), .exec_page(exec_page),
    .rd_page(rd_page), .rd_data(rd_data)
  );

  fcs_pin_filter #(.HOLD(ERASE_HOLD)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_async(erase_pin), .fire(pin_fire)
  );

  fcs_nvm #(
    .REGIONS(REGIONS), .REG_W(REG_W), .CAL_W(CAL_W), .CAL_VALUE(CAL_VALUE)
  ) u_nvm (
    .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .exec_op(exec_op),
    .exec_region(exec_page[PAGE_W-1 -: REG_W]), .exec_sel(exec_page[0]),
    .pin_fire(pin_fire), .lock_bits(lock_bits), .gp_bits(gp_bits),
    .sec_on(sec_on), .sec_armed(sec_armed), .cal_bits(cal_bits)
  );

  assign irq           = done | lock_err | prog_err;
  assign ext_access_ok = ~sec_on;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
#(
  parameter int unsigned REGIONS = 16,
  parameter int unsigned REG_W   = $clog2(REGIONS),
  parameter int unsigned CAL_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_we,
  input logic [7:0]         cmd_key,
  input logic [3:0]         cmd_code,
  input logic [REG_W-1:0]   cmd_region,
  input logic               stat_rd,
  input logic               busy,
  input logic               done,
  input logic               lock_err,
  input logic               prog_err,
  input logic [REGIONS-1:0] lock_bits,
  input logic [1:0]         gp_bits,
  input logic               sec_on,
  input logic [CAL_W-1:0]   cal_bits,
  input logic               pin_fire,
  input logic               exec_valid,
  input fcs_op_e            exec_op,
  input logic               sec_armed
);
  p_bad_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !busy && (cmd_key != CMD_KEY) |=> prog_err && !busy);

  p_done_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_locked_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !busy && (cmd_key == CMD_KEY) && op_hits_page(cmd_code) &&
    lock_bits[cmd_region] |=> !busy && (lock_err || prog_err));

  p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && busy |=> prog_err);

  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !cmd_we && !busy |=> !done && !lock_err && !prog_err);

  p_pin_wipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fire |=> (lock_bits == '0) && (gp_bits == 2'b00));

  p_sec_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_on) |-> $past(exec_valid && (exec_op == OP_FERASE) && sec_armed));

  p_cal_fixed_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cal_bits));
endmodule

bind flash_cmd_seq fcs_checker #(
  .REGIONS(REGIONS), .REG_W(REG_W), .CAL_W(CAL_W)
) u_fcs_checker (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_key(cmd_wdata[31:24]),
  .cmd_code(cmd_wdata[3:0]), .cmd_region(cmd_wdata[8 + PAGE_W - 1 -: REG_W]),
  .stat_rd(stat_rd), .busy(busy), .done(done), .lock_err(lock_err),
  .prog_err(prog_err), .lock_bits(lock_bits), .gp_bits(gp_bits),
  .sec_on(sec_on), .cal_bits(cal_bits), .pin_fire(pin_fire),
  .exec_valid(exec_valid), .exec_op(exec_op), .sec_armed(sec_armed)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n, cmd_we, wbuf_we, stat_rd, erase_pin;
  logic [31:0] cmd_wdata, wbuf_wdata, rd_data;
  logic [9:0]  rd_page;
  logic        busy, done, lock_err, prog_err, irq, sec_on, ext_access_ok;
  logic [15:0] lock_bits;
  logic [1:0]  gp_bits;
  logic [7:0]  cal_bits;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(
    .PROG_CYC(8), .PROGNE_CYC(4), .PERASE_CYC(6), .FERASE_CYC(10),
    .NVM_CYC(3), .ERASE_HOLD(20), .CAL_VALUE(8'h5C)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .wbuf_we(wbuf_we), .wbuf_wdata(wbuf_wdata), .stat_rd(stat_rd),
    .rd_page(rd_page), .rd_data(rd_data), .erase_pin(erase_pin),
    .busy(busy), .done(done), .lock_err(lock_err), .prog_err(prog_err),
    .irq(irq), .lock_bits(lock_bits), .gp_bits(gp_bits), .sec_on(sec_on),
    .ext_access_ok(ext_access_ok), .cal_bits(cal_bits)
  );

  // vector table: command, buffer word, page read back, expected word,
  // expected {done, lock_err, prog_err} after the operation window
  localparam logic [31:0] V_CMD [NV] = '{
    32'hA500_0501, 32'hA500_0502, 32'hA500_0503, 32'hA500_4601, 32'hA500_4005,
    32'hA500_7F01, 32'hA500_4603, 32'hA500_8001, 32'hA500_0004, 32'hA500_6406,
    32'hA500_0004, 32'h5A00_0501, 32'hA500_000F};
  localparam logic [31:0] V_BUF [NV] = '{
    32'h1234_5678, 32'hFFFF_00FF, 32'h0, 32'hCAFE_0001, 32'h0,
    32'h0, 32'h0, 32'h0BAD_F00D, 32'h0, 32'h0,
    32'h0, 32'h1111_1111, 32'h0};
  localparam logic [9:0] V_PAGE [NV] = '{
    10'd5, 10'd5, 10'd5, 10'd70, 10'd70, 10'd127, 10'd70, 10'd128, 10'd128,
    10'd128, 10'd128, 10'd5, 10'd5};
  localparam logic [31:0] V_RD [NV] = '{
    32'h1234_5678, 32'h1234_0078, 32'hFFFF_FFFF, 32'hCAFE_0001, 32'hCAFE_0001,
    32'hFFFF_FFFF, 32'hCAFE_0001, 32'h0BAD_F00D, 32'h0BAD_F00D, 32'h0BAD_F00D,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [2:0] V_FLG [NV] = '{
    3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b010, 3'b010, 3'b100, 3'b010,
    3'b100, 3'b100, 3'b001, 3'b001};
  localparam logic [15:0] V_TAG [NV] = '{
    "R3", "R3", "R4", "R3", "R6", "R5", "R5", "R5", "R5", "R6", "R4", "R1", "R1"};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    cmd_wdata = w;
    cmd_we    = 1'b1;
    @(negedge clk);
    cmd_we    = 1'b0;
  endtask

  task automatic load_buf(input logic [31:0] w);
    wbuf_wdata = w;
    wbuf_we    = 1'b1;
    @(negedge clk);
    wbuf_we    = 1'b0;
  endtask

  task automatic clr();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic peek(input logic [9:0] p);
    rd_page = p;
    #1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    report();
  end

  initial begin
    rst_n = 1'b0; cmd_we = 1'b0; wbuf_we = 1'b0; stat_rd = 1'b0;
    erase_pin = 1'b0; cmd_wdata = '0; wbuf_wdata = '0; rd_page = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // reset state
    peek(10'd0);
    chk("R2 reset flags", 32'({busy, done, lock_err, prog_err, irq}), 32'h0);
    chk("R6 reset locks", 32'(lock_bits), 32'h0);
    chk("R9 reset gp", 32'(gp_bits), 32'h0);
    chk("R10 reset security", 32'({sec_on, ext_access_ok}), 32'h1);
    chk("R13 reset cal", 32'(cal_bits), 32'h5C);
    chk("R4 reset array", rd_data, 32'hFFFF_FFFF);

    // table walk
    for (int i = 0; i < NV; i++) begin
      load_buf(V_BUF[i]);
      issue(V_CMD[i]);
      tick(12);
      peek(V_PAGE[i]);
      chk($sformatf("%s vec%0d data", V_TAG[i], i), rd_data, V_RD[i]);
      chk($sformatf("%s vec%0d flags", V_TAG[i], i),
          32'({busy, done, lock_err, prog_err}), 32'({1'b0, V_FLG[i]}));
      clr();
    end

    // busy window and mid-operation rejection
    load_buf(32'hAAAA_5555);
    issue(32'hA500_0901);
    tick(2);
    issue(32'hA500_0A01);
    chk("R7 reject while busy", 32'({busy, prog_err}), 32'h3);
    tick(4);
    peek(10'd9);
    chk("R2 busy before last edge", 32'({busy, done}), 32'h2);
    chk("R2 no effect before end", rd_data, 32'hFFFF_FFFF);
    tick(1);
    chk("R2 busy falls on time", 32'({busy, done}), 32'h1);
    chk("R8 irq pending", 32'(irq), 32'h1);
    peek(10'd9);
    chk("R3 program result", rd_data, 32'hAAAA_5555);
    peek(10'd10);
    chk("R7 dropped command", rd_data, 32'hFFFF_FFFF);
    clr();
    chk("R8 status read clears", 32'({done, lock_err, prog_err, irq}), 32'h0);

    // general-purpose bits
    issue(32'hA500_0008); tick(4);
    chk("R9 set bit0", 32'(gp_bits), 32'h1);
    issue(32'hA500_0108); tick(4);
    chk("R9 set bit1", 32'(gp_bits), 32'h3);
    issue(32'hA500_0009); tick(4);
    chk("R9 clear bit0", 32'(gp_bits), 32'h2);
    clr();

    // lock region 3 through page 192, security by command
    issue(32'hA500_C005); tick(4);
    chk("R6 lock region 3", 32'(lock_bits), 32'h8);
    issue(32'hA500_0007); tick(4);
    chk("R10 security set", 32'({sec_on, ext_access_ok}), 32'h2);
    clr();
    issue(32'hA500_0004); tick(1);
    chk("R5 full erase refused", 32'({busy, lock_err}), 32'h1);
    clr();
    issue(32'hA500_C006); tick(4);
    issue(32'hA500_0004); tick(12);
    chk("R10 full erase alone keeps security", 32'({sec_on, done}), 32'h3);
    clr();
    issue(32'hA500_C005); tick(4);
    clr();

    // erase pin: short pulse ignored
    erase_pin = 1'b1; tick(15); erase_pin = 1'b0; tick(4);
    chk("R11 short pulse locks", 32'(lock_bits), 32'h8);
    chk("R11 short pulse gp", 32'(gp_bits), 32'h2);

    // erase pin: long pulse honoured
    erase_pin = 1'b1; tick(30); erase_pin = 1'b0; tick(4);
    chk("R11 long pulse locks", 32'(lock_bits), 32'h0);
    chk("R11 long pulse gp", 32'(gp_bits), 32'h0);
    chk("R11 pin alone keeps security", 32'(sec_on), 32'h1);

    issue(32'hA500_0004); tick(12);
    chk("R12 armed full erase clears security", 32'({sec_on, ext_access_ok, done}), 32'h3);
    chk("R13 cal unchanged", 32'(cal_bits), 32'h5C);

    report();
  end
endmodule